// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is the general-purpose register store of a small processor datapath. It holds a set of equal-width registers built from edge-triggered flip-flops. Two read ports, each with its own register number, return stored values combinationally, so the decode stage can fetch both source operands in the same cycle it presents the numbers. One write port, gated by an enable, updates a single register on the rising clock edge.

Register 0 is a hard-wired zero source and sink. When a read names the register that is being written in the same cycle, the read port returns the incoming write data rather than the stored value. This lets a write-back stage and a decode stage share one clock period without a hazard. An asynchronous active-low reset clears every register.

Top module: `regfile_2r1w`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first write, every register reads as zero on both ports.
- R2: When `wr_en_i` is 1 and `wr_addr_i` is nonzero, the register numbered `wr_addr_i` takes `wr_data_i` at the rising edge. From the next cycle, both read ports return that value for that register number.
- R3: When `wr_en_i` is 0, no register changes, whatever `wr_addr_i` and `wr_data_i` carry.
- R4: Register number 0 always reads as zero on both ports. A write to register 0 is discarded and is never forwarded.
- R5: When `wr_en_i` is 1, `wr_addr_i` is nonzero and a read address equals `wr_addr_i`, that read port returns `wr_data_i` in the same cycle, before the edge.
- R6: The two read ports are independent. When both name the same register, they return the same value.
- R7: A write changes only the addressed register. All other registers keep their values.
- R8: A read port's output follows a change of its address within the same cycle, with no clock edge between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears all registers |
| rd_addr_a_i | input | 5 | Register number for read port A |
| rd_data_a_o | output | 32 | Read data for port A |
| rd_addr_b_i | input | 5 | Register number for read port B |
| rd_data_b_o | output | 32 | Read data for port B |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Register number to write |
| wr_data_i | input | 32 | Data to write |

## Verification
The assertions check the following on every clock: the zero register reads as zero, the same-cycle forwarding path matches the write data, and two ports naming one register agree. They also check that a write committed at one edge is read back in the next cycle, and that outputs hold still when no write occurs and the address is unchanged. The bench scenarios are needed for the rest. Reset clears the whole file, including a reset in the middle of a run. A full sweep shows that each write leaves every other register untouched. Read outputs follow address changes between edges, and a disabled write with live address and data lands nowhere.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int unsigned RF_DEPTH = 32;
  parameter int unsigned RF_WIDTH = 32;
  parameter int unsigned RF_READ_PORTS = 2;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned DEPTH  = rf_pkg::RF_DEPTH,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [DEPTH-1:1]  wr_sel_o
);
  // entry 0 is hard-wired zero, so it has no select line
  for (genvar i = 1; i < DEPTH; i++) begin : g_sel
    assign wr_sel_o[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned DEPTH  = rf_pkg::RF_DEPTH,
  parameter int unsigned DATA_W = rf_pkg::RF_WIDTH
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DEPTH-1:1]            wr_sel_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic [DEPTH-1:0][DATA_W-1:0] regs_o
);
  assign regs_o[0] = '0;

  for (genvar i = 1; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          regs_o[i] <= '0;
      else if (wr_sel_i[i]) regs_o[i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned DEPTH  = rf_pkg::RF_DEPTH,
  parameter int unsigned DATA_W = rf_pkg::RF_WIDTH,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] regs_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  input  logic                         wr_en_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [DATA_W-1:0]            rd_data_o
);
  logic fwd_hit;

  // same-cycle write wins over the stored copy; never for entry 0
  assign fwd_hit = wr_en_i && (wr_addr_i == rd_addr_i) && (rd_addr_i != '0);

  always_comb begin
    if (fwd_hit) rd_data_o = wr_data_i;
    else         rd_data_o = regs_i[rd_addr_i];
  end
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w #(
  parameter int unsigned DEPTH  = rf_pkg::RF_DEPTH,
  parameter int unsigned DATA_W = rf_pkg::RF_WIDTH,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_a_i,
  output logic [DATA_W-1:0] rd_data_a_o,
  input  logic [ADDR_W-1:0] rd_addr_b_i,
  output logic [DATA_W-1:0] rd_data_b_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int unsigned NUM_RD = rf_pkg::RF_READ_PORTS;

  logic [DEPTH-1:1]             wr_sel;
  logic [DEPTH-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

  assign rd_addr[0]  = rd_addr_a_i;
  assign rd_addr[1]  = rd_addr_b_i;
  assign rd_data_a_o = rd_data[0];
  assign rd_data_b_o = rd_data[1];

  rf_wr_decode #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_wr_decode (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_sel_o (wr_sel)
  );

  rf_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_storage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data_i),
    .regs_o   (regs)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd_port (
      .regs_i   (regs),
      .rd_addr_i(rd_addr[p]),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .rd_data_o(rd_data[p])
    );
  end
endmodule

// File: rtl/regfile_2r1w_checker.sv
module regfile_2r1w_checker #(
  parameter int unsigned DEPTH  = rf_pkg::RF_DEPTH,
  parameter int unsigned DATA_W = rf_pkg::RF_WIDTH,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rd_addr_a_i,
  input logic [DATA_W-1:0] rd_data_a_o,
  input logic [ADDR_W-1:0] rd_addr_b_i,
  input logic [DATA_W-1:0] rd_data_b_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_zero_reg_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_a_i == '0 |-> rd_data_a_o == '0);
  assert_zero_reg_b_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_b_i == '0 |-> rd_data_b_o == '0);

  assert_fwd_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && rd_addr_a_i == wr_addr_i) |-> rd_data_a_o == wr_data_i);
  assert_fwd_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != '0 && rd_addr_b_i == wr_addr_i) |-> rd_data_b_o == wr_data_i);

  assert_same_reg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_a_i == rd_addr_b_i |-> rd_data_a_o == rd_data_b_o);

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(wr_en_i && wr_addr_i != '0) && !wr_en_i
     && rd_addr_a_i == $past(wr_addr_i)) |-> rd_data_a_o == $past(wr_data_i));

  assert_hold_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(!wr_en_i) && !wr_en_i && $stable(rd_addr_a_i)) |-> $stable(rd_data_a_o));
  assert_hold_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(!wr_en_i) && !wr_en_i && $stable(rd_addr_b_i)) |-> $stable(rd_data_b_o));
endmodule

bind regfile_2r1w regfile_2r1w_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_addr_a_i(rd_addr_a_i),
  .rd_data_a_o(rd_data_a_o),
  .rd_addr_b_i(rd_addr_b_i),
  .rd_data_b_o(rd_data_b_o),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i)
);

// File: tb/test_regfile_2r1w.sv
`timescale 1ns/1ps
module test_regfile_2r1w;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0;
  logic [31:0] model [32];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  regfile_2r1w i_regfile_2r1w (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_addr_a_i(rd_addr_a), .rd_data_a_o(rd_data_a),
    .rd_addr_b_i(rd_addr_b), .rd_data_b_o(rd_data_b),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  function automatic logic [31:0] pat(int i, int s);
    return (32'h9E37_79B9 * (i + 1)) ^ (32'(s) << 16) ^ 32'(i);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  task automatic do_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a != 0) model[a] = d;
  endtask

  task automatic read_chk(string tag, logic [4:0] a, logic [4:0] b);
    rd_addr_a = a; rd_addr_b = b;
    #1;
    chk(tag, rd_data_a, model[a]);
    chk(tag, rd_data_b, model[b]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 32; i++) read_chk("R1 during reset", 5'(i), 5'(31 - i));
    @(negedge clk); rst_ni = 1'b1;
    for (int i = 0; i < 32; i++) read_chk("R1 after reset", 5'(i), 5'(i));
  endtask

  task automatic t_write_read();
    do_write(5'd1, 32'hDEAD_BEEF);
    do_write(5'd31, 32'h0000_0001);
    do_write(5'd16, 32'hFFFF_FFFF);
    read_chk("R2 readback", 5'd1, 5'd31);
    read_chk("R2 readback", 5'd16, 5'd1);
    read_chk("R6 same register", 5'd16, 5'd16);
    read_chk("R7 untouched", 5'd2, 5'd30);
    do_write(5'd1, 32'h1234_5678);
    read_chk("R2 overwrite", 5'd1, 5'd1);
  endtask

  task automatic t_disabled_write();
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd16; wr_data = 32'hA5A5_A5A5;
    rd_addr_a = 5'd16; rd_addr_b = 5'd7;
    #1;
    chk("R3 no forward when disabled", rd_data_a, model[16]);
    @(negedge clk); wr_addr = 5'd7;
    @(negedge clk);
    read_chk("R3 disabled write ignored", 5'd16, 5'd7);
  endtask

  task automatic t_zero_reg();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = 32'hCAFE_F00D;
    rd_addr_a = 5'd0; rd_addr_b = 5'd0;
    #1;
    chk("R4 no forward to r0", rd_data_a, 32'h0);
    chk("R4 no forward to r0", rd_data_b, 32'h0);
    @(negedge clk); wr_en = 1'b0;
    read_chk("R4 r0 stays zero", 5'd0, 5'd0);
  endtask

  task automatic t_forward();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'h5555_AAAA;
    rd_addr_a = 5'd5; rd_addr_b = 5'd5;
    #1;
    chk("R5 forward port A", rd_data_a, 32'h5555_AAAA);
    chk("R5 forward port B", rd_data_b, 32'h5555_AAAA);
    rd_addr_b = 5'd6;
    #0.5;
    chk("R5 other port unaffected", rd_data_b, model[6]);
    @(negedge clk); wr_en = 1'b0; model[5] = 32'h5555_AAAA;
    read_chk("R5 value stored", 5'd5, 5'd6);
  endtask

  task automatic t_comb_read();
    @(negedge clk);
    rd_addr_a = 5'd1; #0.3;
    chk("R8 address change", rd_data_a, model[1]);
    rd_addr_a = 5'd31; #0.3;
    chk("R8 address change", rd_data_a, model[31]);
    rd_addr_a = 5'd16; #0.3;
    chk("R8 address change", rd_data_a, model[16]);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 32; i++) do_write(5'(i), pat(i, 3));
    for (int i = 0; i < 32; i++) read_chk("R7 sweep", 5'(i), 5'(31 - i));
    do_write(5'd9, 32'h0);
    for (int i = 0; i < 32; i++) read_chk("R7 single change", 5'(i), 5'(i));
  endtask

  task automatic t_mid_reset();
    @(negedge clk); rst_ni = 1'b0;
    clear_model();
    #1;
    for (int i = 0; i < 32; i++) read_chk("R1 mid-run reset", 5'(i), 5'(i));
    @(negedge clk); rst_ni = 1'b1;
    read_chk("R1 after second reset", 5'd9, 5'd20);
  endtask

  initial begin
    clear_model();
    t_reset();
    t_write_read();
    t_disabled_write();
    t_zero_reg();
    t_forward();
    t_comb_read();
    t_sweep();
    t_mid_reset();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule